// File: doc/BRIEF.md
# Serial Register-Write Slave

This block is the slave end of a three-wire serial configuration port. A host drives a serial clock, an active-low select and one data line; the block samples the data line on each rising serial-clock edge while select is low. Every transaction opens with an 8-bit header that carries a read/write flag, a flag choosing one or two data bytes, and a 6-bit register address. The data bytes follow and land in an internal 64-entry byte register file. The whole file is presented in parallel to the rest of the chip.

The bit order of a transaction is set by an order flag. This flag is bit 6 of register 0. When it is clear (the reset value), the header and each data byte arrive most significant bit first, and the second byte of a two-byte write goes to the address below the header address. When it is set, the header and data bit order is fully reversed, and the second byte goes to the address above. The serial inputs are brought into the system clock domain and oversampled there, so the host's serial clock must be several system clocks long in each phase.

Top module: `serial_regwr_slave`

## Requirements
- R1: After reset every register in the file reads 0, so the order flag selects most-significant-bit-first transfers.
- R2: A bit is taken only on a rising serial-clock edge while select is low; serial-clock edges while select is high change no register.
- R3: With the order flag clear, the header arrives as R/W, byte count, then address bits 5 down to 0, and each data byte arrives bit 7 first. R/W=0 means write. A byte-count bit of 0 means one data byte and 1 means two.
- R4: With the order flag set, the header arrives as address bit 0 up to bit 5, then the byte count, then R/W, and each data byte arrives bit 0 first.
- R5: With the order flag clear, the second byte of a two-byte write is stored at header address minus one, modulo 64.
- R6: With the order flag set, the second byte of a two-byte write is stored at header address plus one, modulo 64.
- R7: A header with R/W=1 is decoded and its data bytes are consumed, but no register changes.
- R8: A register changes only after all 8 bits of its data byte have arrived. If select rises partway through a byte, that partial byte is dropped, and the next transaction starts with a fresh header.
- R9: The order flag is bit 6 of register 0. A new value written to it takes effect from the next transaction, not within the transaction that writes it. Bit 7 of register 0 is stored like any other bit and has no effect on writes.
- R10: Bits that arrive after the last data byte of a transaction, whether it has one byte or two, are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host, sampled in the clk domain |
| sen_n | input | 1 | Active-low transaction select |
| sdio | input | 1 | Serial data in |
| regs_o | output | 512 | Register file contents; register k occupies bits 8k+7 down to 8k |

## Verification
The bench builds the block with its default parameters: a 6-bit address, 8-bit registers, and the order flag at bit 6 of register 0. With these values the whole 64-entry file is compared every quiet clock against the reference. The wrap of the second-byte address from 0 to 63 can be reached. So can the wrap from 63 to 0, where the second byte lands in the configuration register and the bench can watch the order flag switch between transactions.

// File: rtl/serial_regwr_pkg.sv
package serial_regwr_pkg;
    typedef enum logic [1:0] {
        PH_HDR   = 2'd0,
        PH_BYTE0 = 2'd1,
        PH_BYTE1 = 2'd2,
        PH_DONE  = 2'd3
    } phase_e;
endpackage

// File: rtl/serial_regwr_sync.sv
module serial_regwr_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= din;
            end
        end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/serial_regwr_decode.sv
module serial_regwr_decode
    import serial_regwr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              sen_n_s,
    input  logic              sdio_s,
    input  logic              cfg_lsb,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [$clog2(((ADDR_W+2) > DATA_W ? (ADDR_W+2) : DATA_W)+1)-1:0] bit_cnt
);
    localparam int HDR_W = ADDR_W + 2;
    localparam int SH_W  = (HDR_W > DATA_W) ? HDR_W : DATA_W;
    localparam int CNT_W = $clog2(SH_W + 1);

    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  cnt;
        logic [SH_W-1:0]   sh;
        logic              lsb;
        logic              rd;
        logic              two;
        logic [ADDR_W-1:0] addr;
        logic              sclk_prev;
        logic              we;
        logic [ADDR_W-1:0] wa;
        logic [DATA_W-1:0] wd;
    } st_t;

    st_t st_d, st_q;
    logic             rise;
    logic             last;
    logic [SH_W-1:0]  shn;

    always_comb begin
        st_d           = st_q;
        st_d.we        = 1'b0;
        st_d.sclk_prev = sclk_s;
        rise           = sclk_s & ~st_q.sclk_prev;
        shn            = st_q.sh;
        last           = 1'b0;

        if (sen_n_s) begin
            st_d.phase = PH_HDR;
            st_d.cnt   = '0;
            st_d.sh    = '0;
            st_d.lsb   = cfg_lsb;
        end else if (rise && st_q.phase != PH_DONE) begin
            if (st_q.lsb) shn[st_q.cnt] = sdio_s;
            else          shn = {st_q.sh[SH_W-2:0], sdio_s};

            if (st_q.phase == PH_HDR) last = (st_q.cnt == CNT_W'(HDR_W - 1));
            else                      last = (st_q.cnt == CNT_W'(DATA_W - 1));

            if (!last) begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
                st_d.sh  = shn;
            end else begin
                st_d.cnt = '0;
                st_d.sh  = '0;
                case (st_q.phase)
                    PH_HDR: begin
                        st_d.rd    = shn[HDR_W-1];
                        st_d.two   = shn[HDR_W-2];
                        st_d.addr  = shn[ADDR_W-1:0];
                        st_d.phase = PH_BYTE0;
                    end
                    PH_BYTE0: begin
                        st_d.we    = ~st_q.rd;
                        st_d.wa    = st_q.addr;
                        st_d.wd    = shn[DATA_W-1:0];
                        st_d.addr  = st_q.lsb ? st_q.addr + ADDR_W'(1)
                                              : st_q.addr - ADDR_W'(1);
                        st_d.phase = st_q.two ? PH_BYTE1 : PH_DONE;
                    end
                    default: begin
                        st_d.we    = ~st_q.rd;
                        st_d.wa    = st_q.addr;
                        st_d.wd    = shn[DATA_W-1:0];
                        st_d.phase = PH_DONE;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_HDR;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en   = st_q.we;
    assign wr_addr = st_q.wa;
    assign wr_data = st_q.wd;
    assign bit_cnt = st_q.cnt;
endmodule

// File: rtl/serial_regwr_file.sv
module serial_regwr_file #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              we,
    input  logic [ADDR_W-1:0]                 wa,
    input  logic [DATA_W-1:0]                 wd,
    output logic [(1<<ADDR_W)*DATA_W-1:0]     flat_o
);
    localparam int NUM_REGS = 1 << ADDR_W;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic [DATA_W-1:0] val_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        val_q <= '0;
            else if (we && wa == ADDR_W'(i))   val_q <= wd;
        end
        assign flat_o[i*DATA_W +: DATA_W] = val_q;
    end
endmodule

// File: rtl/serial_regwr_slave.sv
module serial_regwr_slave #(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 8,
    parameter int CFG_ADDR    = 0,
    parameter int LSB_BIT     = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sclk,
    input  logic                          sen_n,
    input  logic                          sdio,
    output logic [(1<<ADDR_W)*DATA_W-1:0] regs_o
);
    localparam int NUM_REGS = 1 << ADDR_W;
    localparam int SH_W     = ((ADDR_W + 2) > DATA_W) ? (ADDR_W + 2) : DATA_W;
    localparam int CNT_W    = $clog2(SH_W + 1);

    logic [2:0]        sync_s;
    logic              sclk_s, sen_s, sdio_s;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [CNT_W-1:0]  bit_cnt;
    logic              cfg_lsb;

    serial_regwr_sync #(
        .W      (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b010)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({sclk, sen_n, sdio}),
        .dout (sync_s)
    );

    assign {sclk_s, sen_s, sdio_s} = sync_s;
    assign cfg_lsb = regs_o[CFG_ADDR*DATA_W + LSB_BIT];

    serial_regwr_decode #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_s (sclk_s),
        .sen_n_s(sen_s),
        .sdio_s (sdio_s),
        .cfg_lsb(cfg_lsb),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .bit_cnt(bit_cnt)
    );

    serial_regwr_file #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_file (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .wa    (wr_addr),
        .wd    (wr_data),
        .flat_o(regs_o)
    );
endmodule

// File: rtl/serial_regwr_slave_chk.sv
module serial_regwr_slave_chk #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          sen_s,
    input logic                          wr_en,
    input logic [ADDR_W-1:0]             wr_addr,
    input logic [DATA_W-1:0]             wr_data,
    input logic [CNT_W-1:0]              bit_cnt,
    input logic [(1<<ADDR_W)*DATA_W-1:0] regs
);
    logic [ADDR_W-1:0] a_q;
    logic [DATA_W-1:0] d_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
            d_q <= '0;
        end else if (wr_en) begin
            a_q <= wr_addr;
            d_q <= wr_data;
        end
    end

    // R8: an idle select clears the partial-byte counter
    p_cnt_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sen_s |=> (bit_cnt == '0));

    // R2: no write strobe follows a cycle with select high
    p_no_write_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sen_s |=> !wr_en);

    // R7: without a write strobe the register file holds
    p_hold_regs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs));

    // R3: a write strobe lands its byte at its address
    p_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (regs[a_q*DATA_W +: DATA_W] == d_q));
endmodule

bind serial_regwr_slave serial_regwr_slave_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .sen_s  (sen_s),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .bit_cnt(bit_cnt),
    .regs   (regs_o)
);

// File: tb/serial_regwr_slave_tb.sv
`timescale 1ns/1ps
module serial_regwr_slave_tb;
    localparam int HALF = 7;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sclk = 1'b0;
    logic         sen_n = 1'b1;
    logic         sdio = 1'b0;
    logic [511:0] regs_o;

    int total = 0;
    int bad = 0;
    bit rst_done = 0;
    bit finished = 0;

    logic [7:0] exp_mem [64];
    int         m_phase, m_cnt, m_addr;
    logic [7:0] m_buf;
    bit         m_rd, m_two, m_lsb;
    bit         bq[$];

    always #4 clk = ~clk;

    serial_regwr_slave u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .sclk  (sclk),
        .sen_n (sen_n),
        .sdio  (sdio),
        .regs_o(regs_o)
    );

    function automatic logic [511:0] exp_flat();
        logic [511:0] f;
        for (int i = 0; i < 64; i++) f[i*8 +: 8] = exp_mem[i];
        return f;
    endfunction

    // reference model, one call per accepted bit
    task automatic model_start();
        m_phase = 0; m_cnt = 0; m_buf = 8'h00; m_lsb = exp_mem[0][6];
    endtask

    task automatic model_bit(bit b);
        if (m_phase == 3) return;
        if (m_lsb) m_buf[m_cnt] = b;
        else       m_buf = {m_buf[6:0], b};
        m_cnt++;
        if (m_cnt == 8) begin
            if (m_phase == 0) begin
                m_rd = m_buf[7]; m_two = m_buf[6]; m_addr = int'(m_buf[5:0]);
                m_phase = 1;
            end else begin
                if (!m_rd) exp_mem[m_addr] = m_buf;
                m_addr = m_lsb ? (m_addr + 1) % 64 : (m_addr + 63) % 64;
                m_phase = (m_phase == 1 && m_two) ? 2 : 3;
            end
            m_cnt = 0; m_buf = 8'h00;
        end
    endtask

    // every-clock comparison once the inputs have been quiet long enough
    logic [2:0] prev_in = 3'b010;
    int quiet = 0;
    always @(posedge clk) begin
        if ({sclk, sen_n, sdio} != prev_in) quiet = 0;
        else quiet++;
        prev_in = {sclk, sen_n, sdio};
        #2;
        if (rst_done && !finished && quiet >= 5) begin
            total++;
            if (regs_o !== exp_flat()) begin
                bad++;
                $display("FAIL R2 model compare: actual=%h expected=%h", regs_o, exp_flat());
            end
        end
    end

    task automatic chk(int a, logic [7:0] e, string tag);
        total++;
        if (regs_o[a*8 +: 8] !== e) begin
            bad++;
            $display("FAIL %s: reg %0d actual=%h expected=%h", tag, a, regs_o[a*8 +: 8], e);
        end
    endtask

    task automatic add_byte(logic [7:0] v, bit lsb);
        for (int i = 0; i < 8; i++) bq.push_back(lsb ? v[i] : v[7-i]);
    endtask

    task automatic hdr(bit rd, bit two, logic [5:0] a, bit lsb);
        add_byte({rd, two, a}, lsb);
    endtask

    task automatic clk_bit(bit b);
        @(negedge clk) sdio = b;
        repeat (HALF) @(negedge clk);
        sclk = 1'b1;
        if (!sen_n) model_bit(b);
        repeat (HALF) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic run_txn(int nbits);
        @(negedge clk) sen_n = 1'b0;
        model_start();
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) clk_bit(bq[i]);
        repeat (HALF) @(negedge clk);
        sen_n = 1'b1;
        repeat (3 * HALF) @(negedge clk);
        bq.delete();
    endtask

    initial begin
        for (int i = 0; i < 64; i++) exp_mem[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        rst_done = 1;

        // R1: reset contents
        total++;
        if (regs_o !== '0) begin
            bad++;
            $display("FAIL R1: actual=%h expected=0", regs_o);
        end

        // R2: clocks with select high are ignored
        for (int i = 0; i < 16; i++) clk_bit(i[0] ^ i[2]);
        repeat (3 * HALF) @(negedge clk);
        chk(0, 8'h00, "R2");
        chk(5, 8'h00, "R2");

        // R3: MSB-first single byte
        hdr(0, 0, 6'd5, 0); add_byte(8'hA5, 0); run_txn(bq.size());
        chk(5, 8'hA5, "R3");
        chk(4, 8'h00, "R3");

        // R5: MSB-first two bytes, second at N-1
        hdr(0, 1, 6'd10, 0); add_byte(8'h11, 0); add_byte(8'h22, 0); run_txn(bq.size());
        chk(10, 8'h11, "R5");
        chk(9, 8'h22, "R5");
        chk(11, 8'h00, "R5");

        // R5: wrap 0 -> 63
        hdr(0, 1, 6'd0, 0); add_byte(8'h00, 0); add_byte(8'h3C, 0); run_txn(bq.size());
        chk(63, 8'h3C, "R5 wrap");

        // R7: read header changes nothing
        hdr(1, 1, 6'd20, 0); add_byte(8'hFF, 0); add_byte(8'hEE, 0); run_txn(bq.size());
        chk(20, 8'h00, "R7");
        chk(19, 8'h00, "R7");

        // R8: abort mid byte, then a fresh transaction
        hdr(0, 0, 6'd30, 0); add_byte(8'hFF, 0); run_txn(13);
        chk(30, 8'h00, "R8 partial");
        hdr(0, 0, 6'd31, 0); add_byte(8'h5A, 0); run_txn(bq.size());
        chk(31, 8'h5A, "R8 fresh");
        chk(30, 8'h00, "R8 fresh");

        // R10: extra bits after a single byte
        hdr(0, 0, 6'd40, 0); add_byte(8'h77, 0); add_byte(8'h99, 0); run_txn(bq.size());
        chk(40, 8'h77, "R10");
        chk(39, 8'h00, "R10");
        chk(41, 8'h00, "R10");

        // R9: order flag written mid transaction applies only later
        hdr(0, 1, 6'd1, 0); add_byte(8'h12, 0); add_byte(8'h40, 0); run_txn(bq.size());
        chk(1, 8'h12, "R9");
        chk(0, 8'h40, "R9");

        // R4: LSB-first single byte
        hdr(0, 0, 6'd7, 1); add_byte(8'h1D, 1); run_txn(bq.size());
        chk(7, 8'h1D, "R4");

        // R6: LSB-first two bytes, second at N+1
        hdr(0, 1, 6'd50, 1); add_byte(8'hA1, 1); add_byte(8'hB2, 1); run_txn(bq.size());
        chk(50, 8'hA1, "R6");
        chk(51, 8'hB2, "R6");
        chk(49, 8'h00, "R6");

        // R6 wrap 63 -> 0, setting the bidirectional flag too
        hdr(0, 1, 6'd63, 1); add_byte(8'h6B, 1); add_byte(8'hC0, 1); run_txn(bq.size());
        chk(63, 8'h6B, "R6 wrap");
        chk(0, 8'hC0, "R6 wrap");

        // R9: bit 7 of register 0 has no effect on writes
        hdr(0, 0, 6'd12, 1); add_byte(8'h3E, 1); run_txn(bq.size());
        chk(12, 8'h3E, "R9 bidir");

        // R10: extra bits after two bytes in LSB-first order
        hdr(0, 1, 6'd14, 1); add_byte(8'h01, 1); add_byte(8'h02, 1); add_byte(8'h55, 1);
        run_txn(bq.size());
        chk(14, 8'h01, "R10");
        chk(15, 8'h02, "R10");
        chk(16, 8'h00, "R10");

        // R9: clear the flag, then MSB-first again
        hdr(0, 0, 6'd0, 1); add_byte(8'h00, 1); run_txn(bq.size());
        chk(0, 8'h00, "R9");
        hdr(0, 0, 6'd2, 0); add_byte(8'h81, 0); run_txn(bq.size());
        chk(2, 8'h81, "R9 back to MSB");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule